// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block generates the individual bus cycles of a raw 8-bit NAND flash device. A host hands it one request at a time: a byte with a kind code that marks it as a command, an address, a data write or a data read. The block then drives the command-latch and address-latch enables, the active-low write and read strobes and the data bus with its output enable. Every cycle has three phases: a setup phase in which the latch enables and data settle, a strobe phase in which the write or read strobe is low, and a hold phase in which the strobe is released while the data stays on the bus. Each phase length is a count of clocks.

The phase counts come from nanosecond figures that the host loads. The block converts each figure to clocks with the clock rate given as a parameter, and it refuses a set in which any figure needs more clocks than its field can hold. The chip-enable line is a separate register bit that only the host moves. The device ready/busy pin passes through a synchronizer to a status output. A parameter selects a narrow setup field of 2 bits or a wide one of 3 bits.

Top module: `nand_cycle_seq`

## Requirements
- R1: A request of kind 1 (command) drives CLE high and ALE low for the whole cycle, with the byte on the data bus and the output enable high.
- R2: Kind 3 (data write) drives neither CLE nor ALE. Kind 2 and every unassigned kind (5, 6, 7) is an address cycle with ALE high and CLE low. CLE and ALE are never high together.
- R3: Kind 0 (no command) is accepted but starts no bus cycle: req_ready stays high and all strobes stay inactive.
- R4: An accepted cycle lasts S clocks of setup with both strobes high, then W clocks with the strobe low, then H clocks with the strobe high and data still driven. The block then returns to idle. S, W and H are the loaded counts.
- R5: Kind 4 (data read) has the same phases, but nRE is low in place of nWE and the output enable is low. rd_data takes nand_dq_in on the last strobe clock, and rd_valid pulses once. nWE and nRE are never low together.
- R6: Each phase count is stored as count minus one. Strobe and hold cover 1 to 8 clocks. Setup covers 1 to 4 clocks when WIDE_SETUP=0 and 1 to 8 clocks when WIDE_SETUP=1.
- R7: A pulse on tim_load converts each nanosecond input to floor(ns * CLK_KHZ / 1000000) + 1 clocks.
- R8: If any converted count on a load exceeds its field range, tim_err goes high and all three stored counts are kept. A load that fits clears tim_err. tim_err rises only after a load.
- R9: After reset the counts are at their maxima (setup 4 on the narrow variant, strobe 8, hold 8), nand_nce is 1, tim_err is 0 and req_ready is 1.
- R10: A clock with ce_wr high sets nand_nce to the inverse of ce_sel from the next clock on (ce_sel=1 selects, nce=0). Without ce_wr, nand_nce does not change.
- R11: dev_ready follows nand_rb, where 1 means ready, through two flops. A change on the pin appears after the second rising edge and not after the first. The flops reset to 0.
- R12: req_ready is low from the clock after acceptance until the hold phase ends. A request held valid during that time is not lost: it is accepted when req_ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tim_load | input | 1 | Load the three timing figures |
| tim_setup_ns | input | NS_W | Setup time in ns |
| tim_strobe_ns | input | NS_W | Strobe time in ns |
| tim_hold_ns | input | NS_W | Hold time in ns |
| tim_err | output | 1 | Last load was rejected |
| ce_wr | input | 1 | Write the chip-enable bit |
| ce_sel | input | 1 | 1 selects the device, 0 deselects it |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Request kind code |
| req_byte | input | DATA_W | Byte to drive |
| req_ready | output | 1 | Block idle, request accepted this clock if valid |
| rd_data | output | DATA_W | Byte captured by the last read cycle |
| rd_valid | output | 1 | One-clock pulse when rd_data is updated |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_nwe | output | 1 | Write strobe, active low |
| nand_nre | output | 1 | Read strobe, active low |
| nand_nce | output | 1 | Chip enable, active low |
| nand_dq_out | output | DATA_W | Data bus, driven value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | DATA_W | Data bus, sampled value |
| nand_rb | input | 1 | Device ready/busy pin, 1 = ready |
| dev_ready | output | 1 | Synchronized ready status |

## Verification
The bench sweeps every setup, strobe and hold combination of the narrow variant and measures each phase length at the pins. A counter that is off by one, or that loads the wrong field, shows up as a wrong length in one phase. It loads figures just past the narrow setup limit and past the 8-clock limit. A design that clamps these values, or keeps only part of a rejected set, would produce the wrong lengths on the next cycle. Kind codes 5 to 7 must still act as address cycles, and the no-command code must leave the bus quiet. A request held valid during a cycle must be carried out afterwards and not dropped. The ready synchronizer must show exactly two clocks of delay.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
   localparam logic [2:0] KIND_NONE  = 3'd0;
   localparam logic [2:0] KIND_CMD   = 3'd1;
   localparam logic [2:0] KIND_ADDR  = 3'd2;
   localparam logic [2:0] KIND_WDATA = 3'd3;
   localparam logic [2:0] KIND_RDATA = 3'd4;

   localparam int PH_CNT_W = 3;   // strobe/hold field width, also counter width

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_t;
endpackage

// File: rtl/nand_seq_timing.sv
module nand_seq_timing #(
   parameter int NS_W    = 8,
   parameter int CLK_KHZ = 100000,
   parameter int SETUP_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [NS_W-1:0]    setup_ns,
   input  logic [NS_W-1:0]    strobe_ns,
   input  logic [NS_W-1:0]    hold_ns,
   output logic [SETUP_W-1:0] setup_m1,
   output logic [nand_seq_pkg::PH_CNT_W-1:0] strobe_m1,
   output logic [nand_seq_pkg::PH_CNT_W-1:0] hold_m1,
   output logic               err
);
   import nand_seq_pkg::*;

   localparam int PROD_W = NS_W + 32;
   localparam int NFIELD = 3;

   logic [NS_W-1:0]   ns_v  [NFIELD];
   logic [PROD_W-1:0] ticks [NFIELD];
   logic [NFIELD-1:0] fits;

   assign ns_v[0] = setup_ns;
   assign ns_v[1] = strobe_ns;
   assign ns_v[2] = hold_ns;

   // Clocks minus one = floor(ns * kHz / 1e6); each field has its own ceiling.
   for (genvar i = 0; i < NFIELD; i++) begin : g_conv
      localparam int FW  = (i == 0) ? SETUP_W : PH_CNT_W;
      localparam int LIM = (1 << FW) - 1;
      assign ticks[i] = (PROD_W'(ns_v[i]) * PROD_W'(CLK_KHZ)) / PROD_W'(1000000);
      assign fits[i]  = (ticks[i] <= PROD_W'(LIM));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_m1  <= '1;
         strobe_m1 <= '1;
         hold_m1   <= '1;
         err       <= 1'b0;
      end else if (load) begin
         if (&fits) begin
            setup_m1  <= ticks[0][SETUP_W-1:0];
            strobe_m1 <= ticks[1][PH_CNT_W-1:0];
            hold_m1   <= ticks[2][PH_CNT_W-1:0];
            err       <= 1'b0;
         end else begin
            err       <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm #(
   parameter int DATA_W  = 8,
   parameter int SETUP_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [2:0]         req_kind,
   input  logic [DATA_W-1:0]  req_byte,
   output logic               req_ready,
   input  logic [SETUP_W-1:0] setup_m1,
   input  logic [nand_seq_pkg::PH_CNT_W-1:0] strobe_m1,
   input  logic [nand_seq_pkg::PH_CNT_W-1:0] hold_m1,
   input  logic [DATA_W-1:0]  dq_in,
   output logic               cle,
   output logic               ale,
   output logic               nwe,
   output logic               nre,
   output logic [DATA_W-1:0]  dq_out,
   output logic               dq_oe,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rd_valid
);
   import nand_seq_pkg::*;

   phase_t              phase;
   logic [PH_CNT_W-1:0] cnt;
   logic [2:0]          kind_q;
   logic [DATA_W-1:0]   byte_q;
   logic                active, is_cmd, is_wr, is_rd, is_addr, last;

   assign req_ready = (phase == PH_IDLE);
   assign active    = !req_ready;
   assign last      = (cnt == '0);

   assign is_cmd  = (kind_q == KIND_CMD);
   assign is_wr   = (kind_q == KIND_WDATA);
   assign is_rd   = (kind_q == KIND_RDATA);
   assign is_addr = !is_cmd && !is_wr && !is_rd && (kind_q != KIND_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cnt      <= '0;
         kind_q   <= KIND_NONE;
         byte_q   <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (req_valid && req_kind != KIND_NONE) begin
                  phase  <= PH_SETUP;
                  cnt    <= PH_CNT_W'(setup_m1);
                  kind_q <= req_kind;
                  byte_q <= req_byte;
               end
            end
            PH_SETUP: begin
               if (last) begin
                  phase <= PH_STROBE;
                  cnt   <= strobe_m1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_STROBE: begin
               if (last) begin
                  phase <= PH_HOLD;
                  cnt   <= hold_m1;
                  if (is_rd) begin
                     rd_data  <= dq_in;
                     rd_valid <= 1'b1;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_HOLD: begin
               if (last) phase <= PH_IDLE;
               else      cnt   <= cnt - 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign cle    = active && is_cmd;
   assign ale    = active && is_addr;
   assign nwe    = !((phase == PH_STROBE) && !is_rd);
   assign nre    = !((phase == PH_STROBE) && is_rd);
   assign dq_oe  = active && !is_rd;
   assign dq_out = byte_q;
endmodule

// File: rtl/nand_seq_sync.sv
module nand_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq #(
   parameter int DATA_W     = 8,
   parameter int NS_W       = 8,
   parameter int CLK_KHZ    = 100000,
   parameter bit WIDE_SETUP = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tim_load,
   input  logic [NS_W-1:0]   tim_setup_ns,
   input  logic [NS_W-1:0]   tim_strobe_ns,
   input  logic [NS_W-1:0]   tim_hold_ns,
   output logic              tim_err,
   input  logic              ce_wr,
   input  logic              ce_sel,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [DATA_W-1:0] req_byte,
   output logic              req_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_nwe,
   output logic              nand_nre,
   output logic              nand_nce,
   output logic [DATA_W-1:0] nand_dq_out,
   output logic              nand_dq_oe,
   input  logic [DATA_W-1:0] nand_dq_in,
   input  logic              nand_rb,
   output logic              dev_ready
);
   import nand_seq_pkg::*;

   localparam int SETUP_W = WIDE_SETUP ? PH_CNT_W : 2;

   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (CLK_KHZ < 1) begin : g_bad_clk
      $error("CLK_KHZ must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SETUP_W-1:0]  setup_m1;
   logic [PH_CNT_W-1:0] strobe_m1, hold_m1;

   nand_seq_timing #(.NS_W(NS_W), .CLK_KHZ(CLK_KHZ), .SETUP_W(SETUP_W)) u_timing (
      .clk(clk), .rst_n(rst_n), .load(tim_load),
      .setup_ns(tim_setup_ns), .strobe_ns(tim_strobe_ns), .hold_ns(tim_hold_ns),
      .setup_m1(setup_m1), .strobe_m1(strobe_m1), .hold_m1(hold_m1), .err(tim_err)
   );

   nand_seq_fsm #(.DATA_W(DATA_W), .SETUP_W(SETUP_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_kind(req_kind), .req_byte(req_byte), .req_ready(req_ready),
      .setup_m1(setup_m1), .strobe_m1(strobe_m1), .hold_m1(hold_m1),
      .dq_in(nand_dq_in),
      .cle(nand_cle), .ale(nand_ale), .nwe(nand_nwe), .nre(nand_nre),
      .dq_out(nand_dq_out), .dq_oe(nand_dq_oe),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   nand_seq_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
      .clk(clk), .rst_n(rst_n), .d(nand_rb), .q(dev_ready)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     nand_nce <= 1'b1;
      else if (ce_wr) nand_nce <= !ce_sel;
   end
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic cle,
   input logic ale,
   input logic nwe,
   input logic nre,
   input logic nce,
   input logic dq_oe,
   input logic req_ready,
   input logic ce_wr,
   input logic tim_load,
   input logic tim_err,
   input logic rb,
   input logic dev_ready
);
   logic [1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        age <= '0;
      else if (age != 2'd3) age <= age + 1'b1;
   end

   assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));

   assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nwe && !nre));

   assert_read_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !nre |-> !dq_oe);

   assert_busy_in_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!nwe || !nre) |-> !req_ready);

   assert_data_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nwe) |-> (dq_oe && !req_ready));

   assert_nce_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ce_wr) |-> $stable(nce));

   assert_err_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tim_err) |-> $past(tim_load));

   assert_sync_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (dev_ready == $past(rb, 2)));
endmodule

bind nand_cycle_seq nand_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cle(nand_cle), .ale(nand_ale), .nwe(nand_nwe),
   .nre(nand_nre), .nce(nand_nce), .dq_oe(nand_dq_oe), .req_ready(req_ready),
   .ce_wr(ce_wr), .tim_load(tim_load), .tim_err(tim_err), .rb(nand_rb),
   .dev_ready(dev_ready)
);

// File: tb/sim_nand_cycle_seq.sv
`timescale 1ns/1ps
module sim_nand_cycle_seq;
   localparam int KHZ = 250000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tim_load = 1'b0;
   logic [7:0] tim_setup_ns = '0, tim_strobe_ns = '0, tim_hold_ns = '0;
   logic       tim_err;
   logic       ce_wr = 1'b0, ce_sel = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_kind = '0;
   logic [7:0] req_byte = '0;
   logic       req_ready;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic       nand_cle, nand_ale, nand_nwe, nand_nre, nand_nce, nand_dq_oe;
   logic [7:0] nand_dq_out;
   logic [7:0] nand_dq_in = 8'h00;
   logic       nand_rb = 1'b0;
   logic       dev_ready;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   nand_cycle_seq #(.CLK_KHZ(KHZ), .WIDE_SETUP(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .tim_load(tim_load), .tim_setup_ns(tim_setup_ns),
      .tim_strobe_ns(tim_strobe_ns), .tim_hold_ns(tim_hold_ns), .tim_err(tim_err),
      .ce_wr(ce_wr), .ce_sel(ce_sel), .req_valid(req_valid), .req_kind(req_kind),
      .req_byte(req_byte), .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
      .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_nwe(nand_nwe), .nand_nre(nand_nre),
      .nand_nce(nand_nce), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
      .nand_dq_in(nand_dq_in), .nand_rb(nand_rb), .dev_ready(dev_ready)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int to_clks(input int ns);
      return (ns * KHZ) / 1000000 + 1;
   endfunction

   task automatic load_ns(input int s, input int w, input int h);
      @(negedge clk);
      tim_setup_ns = 8'(s); tim_strobe_ns = 8'(w); tim_hold_ns = 8'(h);
      tim_load = 1'b1;
      @(negedge clk);
      tim_load = 1'b0;
   endtask

   // Issue one request; measure setup/strobe/hold lengths and pin behaviour.
   task automatic run_cycle(input logic [2:0] kind, input logic [7:0] b,
                            output int s, output int w, output int h,
                            output bit sig_ok, output bit rv_seen);
      bit exp_cle, exp_ale, exp_oe, rd;
      rd      = (kind == 3'd4);
      exp_cle = (kind == 3'd1);
      exp_ale = (kind == 3'd2) || (kind >= 3'd5);
      exp_oe  = !rd;
      s = 0; w = 0; h = 0; sig_ok = 1'b1; rv_seen = 1'b0;
      @(negedge clk);
      req_kind = kind; req_byte = b; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (nand_nwe && nand_nre && !req_ready) begin
         if (nand_cle != exp_cle || nand_ale != exp_ale || nand_dq_oe != exp_oe) sig_ok = 1'b0;
         if (exp_oe && nand_dq_out != b) sig_ok = 1'b0;
         s++; @(negedge clk);
      end
      while (!nand_nwe || !nand_nre) begin
         if (rd ? nand_nwe == 1'b0 : nand_nre == 1'b0) sig_ok = 1'b0;
         if (nand_cle != exp_cle || nand_ale != exp_ale || nand_dq_oe != exp_oe) sig_ok = 1'b0;
         if (exp_oe && nand_dq_out != b) sig_ok = 1'b0;
         w++; @(negedge clk);
      end
      while (!req_ready) begin
         if (rd_valid) rv_seen = 1'b1;
         if (nand_cle != exp_cle || nand_ale != exp_ale || nand_dq_oe != exp_oe) sig_ok = 1'b0;
         if (exp_oe && nand_dq_out != b) sig_ok = 1'b0;
         h++; @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int s, w, h, idx;
      bit ok, rv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      check(nand_nce == 1'b1, "R9 nce after reset", nand_nce, 1);
      check(tim_err == 1'b0, "R9 tim_err after reset", tim_err, 0);
      check(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
      run_cycle(3'd1, 8'h70, s, w, h, ok, rv);
      check(s == 4, "R9 default setup", s, 4);
      check(w == 8, "R9 default strobe", w, 8);
      check(h == 8, "R9 default hold", h, 8);
      check(ok, "R1 command pins", ok, 1);

      // R4 R6 R7 R1 R2: full sweep of the narrow configuration
      idx = 0;
      for (int ss = 1; ss <= 4; ss++)
         for (int ww = 1; ww <= 8; ww++)
            for (int hh = 1; hh <= 8; hh++) begin
               int ns_s, ns_w, ns_h;
               logic [2:0] k;
               ns_s = (ss - 1) * 4 + (ww % 4);
               ns_w = (ww - 1) * 4 + (hh % 4);
               ns_h = (hh - 1) * 4 + (ss % 4);
               load_ns(ns_s, ns_w, ns_h);
               k = 3'(1 + (idx % 7));
               nand_dq_in = 8'(idx * 13 + 5);
               run_cycle(k, 8'(idx * 37), s, w, h, ok, rv);
               check(s == to_clks(ns_s) && w == to_clks(ns_w) && h == to_clks(ns_h),
                     "R4 R7 phase lengths", s * 100 + w * 10 + h,
                     to_clks(ns_s) * 100 + to_clks(ns_w) * 10 + to_clks(ns_h));
               check(ok, "R1 R2 R5 pin levels for kind", k, k);
               if (k == 3'd4) begin
                  check(rv && rd_data == 8'(idx * 13 + 5), "R5 read capture",
                        rd_data, idx * 13 + 5);
               end
               idx++;
            end

      // R8: narrow setup limit 15ns -> 4 fits, 16ns -> 5 rejected
      load_ns(4, 8, 12);   // 2,3,4
      check(tim_err == 1'b0, "R8 good load", tim_err, 0);
      load_ns(16, 0, 0);
      check(tim_err == 1'b1, "R8 setup over narrow limit", tim_err, 1);
      run_cycle(3'd3, 8'h3C, s, w, h, ok, rv);
      check(s == 2 && w == 3 && h == 4, "R8 R6 kept after reject", s * 100 + w * 10 + h, 234);
      load_ns(0, 32, 0);
      check(tim_err == 1'b1, "R8 strobe over 8", tim_err, 1);
      run_cycle(3'd2, 8'h11, s, w, h, ok, rv);
      check(s == 2 && w == 3 && h == 4, "R8 kept after strobe reject", s * 100 + w * 10 + h, 234);
      load_ns(15, 31, 31);
      check(tim_err == 1'b0, "R8 boundary load clears err", tim_err, 1'b0);
      run_cycle(3'd1, 8'hFF, s, w, h, ok, rv);
      check(s == 4 && w == 8 && h == 8, "R6 field maxima", s * 100 + w * 10 + h, 488);

      // R3: no-command request
      load_ns(0, 0, 0);
      @(negedge clk);
      req_kind = 3'd0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      ok = 1'b1;
      for (int i = 0; i < 4; i++) begin
         if (!req_ready || nand_cle || nand_ale || !nand_nwe || !nand_nre || nand_dq_oe) ok = 1'b0;
         @(negedge clk);
      end
      check(ok, "R3 no bus cycle", ok, 1);

      // R12: request held valid during a cycle is taken afterwards
      load_ns(4, 4, 4);    // 2,2,2
      @(negedge clk);
      req_kind = 3'd1; req_byte = 8'hA1; req_valid = 1'b1;
      @(negedge clk);      // accepted at last edge
      check(!req_ready, "R12 busy after accept", req_ready, 0);
      req_kind = 3'd2; req_byte = 8'hB2;
      s = 0;
      while (!req_ready) begin s++; @(negedge clk); end
      check(s == 6, "R12 busy length", s, 6);
      @(negedge clk);      // second request accepted
      req_valid = 1'b0;
      check(nand_ale && !nand_cle && nand_dq_out == 8'hB2, "R12 stalled request kept",
            nand_dq_out, 8'hB2);
      while (!req_ready) @(negedge clk);

      // R10 chip enable
      @(negedge clk); ce_sel = 1'b1; ce_wr = 1'b1;
      @(negedge clk); ce_wr = 1'b0;
      check(nand_nce == 1'b0, "R10 select", nand_nce, 0);
      ce_sel = 1'b0;
      @(negedge clk);
      check(nand_nce == 1'b0, "R10 no write no change", nand_nce, 0);
      ce_wr = 1'b1;
      @(negedge clk); ce_wr = 1'b0;
      check(nand_nce == 1'b1, "R10 deselect", nand_nce, 1);

      // R11 ready synchronizer
      check(dev_ready == 1'b0, "R11 reset value", dev_ready, 0);
      nand_rb = 1'b1;
      @(negedge clk);
      check(dev_ready == 1'b0, "R11 not after one edge", dev_ready, 0);
      @(negedge clk);
      check(dev_ready == 1'b1, "R11 after two edges", dev_ready, 1);
      nand_rb = 1'b0;
      @(negedge clk);
      check(dev_ready == 1'b1, "R11 fall not after one edge", dev_ready, 1);
      @(negedge clk);
      check(dev_ready == 1'b0, "R11 fall after two edges", dev_ready, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule